// File: doc/BRIEF.md
# Byte FIFO with Role-Dependent Status Word

This block is a synchronous, byte-wide first-in first-out buffer that sits between a serial line engine and a register interface. One instance can serve as the receive buffer, filled by the line receiver and drained by software. Another instance can serve as the transmit buffer, filled by software and drained by the line transmitter. A parameter fixes the role. The role changes only the meaning of the two lowest status bits, so each bit can drive an interrupt line directly.

Each clock edge can accept a write strobe with a byte and a read strobe. The block returns a non-empty flag, the byte most recently popped, a 16-bit status word and a sticky error flag. The status word packs the fill level, the configured size and the two interrupt bits. A synchronous reset empties the buffer. The owner asserts it for system reset, for a line break or for a software-requested flush.

Top module: `byte_fifo_stat`

## Requirements
- R1: The depth is 2^A, where A is the `LOG2_DEPTH` parameter clamped to the range 2..10. Status bits [15:12] always read A.
- R2: A write strobe on a non-full buffer stores the byte. The fill level and the non-empty flag reflect the write right after the same clock edge.
- R3: Bytes leave in the order they were written. After the clock edge that accepts a read strobe, `rd_byte` holds the popped byte and keeps it until the next accepted read.
- R4: If both strobes are asserted while the buffer holds at least one byte, both operations take effect and the fill level is unchanged. This also applies when the buffer is full.
- R5: A read strobe on an empty buffer pops nothing, leaves `rd_byte` unchanged and sets `err`.
- R6: A write strobe on a full buffer without a read strobe is dropped. The stored contents and the fill level stay the same, and `err` is set.
- R7: Once set, `err` stays set until reset.
- R8: Status bits [A+1:2] hold the fill level modulo 2^A, so a full buffer reads 0 there. Status bits [11:A+2] read 0.
- R9: In the receive role (`ROLE` = ROLE_RX), status bit 0 is 1 when the fill level is non-zero, and status bit 1 is 1 when the fill level exceeds half the depth.
- R10: In the transmit role (`ROLE` = ROLE_TX), status bit 0 is 1 when the fill level is below the depth, and status bit 1 is 1 when the fill level is below half the depth.
- R11: A synchronous reset empties the buffer and clears `err`, `nonempty` and `rd_byte` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, flushes the buffer |
| wr_en | input | 1 | Write strobe |
| wr_byte | input | 8 | Byte to store |
| rd_en | input | 1 | Read strobe |
| nonempty | output | 1 | Buffer holds at least one byte |
| rd_byte | output | 8 | Byte popped by the last accepted read |
| status | output | 16 | Size, fill level and role-dependent interrupt bits |
| err | output | 1 | Sticky illegal-access flag |

## Verification
Every result of a strobe is due at the first clock edge that samples it. Fill level, flags, status and error come from registers updated at that edge. `rd_byte` is loaded at that same edge from the head entry. No result waits a second cycle. The bench drives each strobe at a falling edge and compares all outputs one nanosecond after the next rising edge against a queue model that was advanced at that edge. No check ever waits across a second edge.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic {
        ROLE_TX = 1'b0,
        ROLE_RX = 1'b1
    } bfs_role_e;

    // Legal range for the address width of the buffer.
    function automatic int clamp_lg(int lg);
        if (lg < 2)  return 2;
        if (lg > 10) return 10;
        return lg;
    endfunction

endpackage

// File: rtl/bfs_ctrl.sv
module bfs_ctrl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [AW:0]   fill,
    output logic          err
);
    localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW:0]   fill;
        logic          err;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  empty_w, full_w;

    always_comb begin
        empty_w = (st_q.fill == '0);
        full_w  = (st_q.fill == DEPTH);
        rd_ok   = rd_req && !empty_w;
        wr_ok   = wr_req && (!full_w || rd_ok);

        st_d      = st_q;
        st_d.wptr = st_q.wptr + AW'(wr_ok);
        st_d.rptr = st_q.rptr + AW'(rd_ok);
        st_d.fill = st_q.fill + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
        st_d.err  = st_q.err || (rd_req && empty_w) || (wr_req && !wr_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wptr = st_q.wptr;
    assign rptr = st_q.rptr;
    assign fill = st_q.fill;
    assign err  = st_q.err;

endmodule

// File: rtl/bfs_store.sv
module bfs_store #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] dout_d, dout_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    always_comb begin
        dout_d = dout_q;
        if (rd_en) dout_d = mem_q[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) dout_q <= '0;
        else     dout_q <= dout_d;
    end

    assign rd_data = dout_q;

endmodule

// File: rtl/bfs_status.sv
module bfs_status
    import bfs_pkg::*;
#(
    parameter int        AW   = 4,
    parameter bfs_role_e ROLE = ROLE_RX
) (
    input  logic [AW:0] fill,
    output logic [15:0] status
);
    localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);
    localparam logic [AW:0] HALF  = (AW+1)'(1 << (AW-1));

    logic [1:0] irq_w;

    generate
        if (ROLE == ROLE_RX) begin : g_rx
            assign irq_w[0] = (fill != '0);
            assign irq_w[1] = (fill > HALF);
        end else begin : g_tx
            assign irq_w[0] = (fill != DEPTH);
            assign irq_w[1] = (fill < HALF);
        end
    endgenerate

    always_comb begin
        status           = '0;
        status[15:12]    = 4'(AW);
        status[AW+1:2]   = fill[AW-1:0];
        status[1:0]      = irq_w;
    end

endmodule

// File: rtl/byte_fifo_stat.sv
module byte_fifo_stat
    import bfs_pkg::*;
#(
    parameter int        LOG2_DEPTH = 4,
    parameter bfs_role_e ROLE       = ROLE_RX
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_byte,
    input  logic        rd_en,
    output logic        nonempty,
    output logic [7:0]  rd_byte,
    output logic [15:0] status,
    output logic        err
);
    localparam int AW = clamp_lg(LOG2_DEPTH);

    logic          wr_ok_w, rd_ok_w;
    logic [AW-1:0] wptr_w, rptr_w;
    logic [AW:0]   fill_w;

    bfs_ctrl #(.AW(AW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_en),
        .rd_req (rd_en),
        .wr_ok  (wr_ok_w),
        .rd_ok  (rd_ok_w),
        .wptr   (wptr_w),
        .rptr   (rptr_w),
        .fill   (fill_w),
        .err    (err)
    );

    bfs_store #(.AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok_w),
        .wr_addr (wptr_w),
        .wr_data (wr_byte),
        .rd_en   (rd_ok_w),
        .rd_addr (rptr_w),
        .rd_data (rd_byte)
    );

    bfs_status #(.AW(AW), .ROLE(ROLE)) u_status (
        .fill   (fill_w),
        .status (status)
    );

    assign nonempty = (fill_w != '0);

endmodule

// File: rtl/byte_fifo_stat_chk.sv
module byte_fifo_stat_chk #(
    parameter int AW = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic        nonempty,
    input logic        err,
    input logic [AW:0] fill
);
    localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= DEPTH);

    // R2
    push_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && fill < DEPTH) |=> (fill == $past(fill) + 1'b1) && nonempty);

    // R4
    both_keep_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && nonempty) |=> $stable(fill));

    // R5
    empty_read_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !nonempty) |=> err);

    // R6
    full_write_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && fill == DEPTH) |=> err && $stable(fill));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (fill == '0) && !err && !nonempty);

endmodule

bind byte_fifo_stat byte_fifo_stat_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .nonempty (nonempty),
    .err      (err),
    .fill     (fill_w)
);

// File: tb/tb_byte_fifo_stat.sv
`timescale 1ns/1ps
module tb_byte_fifo_stat;
    import bfs_pkg::*;

    localparam int D = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [7:0] wr_byte = '0;

    logic        ne_rx, ne_tx, err_rx, err_tx;
    logic [7:0]  rd_rx, rd_tx;
    logic [15:0] st_rx, st_tx;

    always #2.5 clk = ~clk;

    byte_fifo_stat #(.LOG2_DEPTH(2), .ROLE(ROLE_RX)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .rd_en(rd_en),
        .nonempty(ne_rx), .rd_byte(rd_rx), .status(st_rx), .err(err_rx));

    // LOG2_DEPTH below the legal range: clamps to 2 (R1)
    byte_fifo_stat #(.LOG2_DEPTH(1), .ROLE(ROLE_TX)) dut_tx (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .rd_en(rd_en),
        .nonempty(ne_tx), .rd_byte(rd_tx), .status(st_tx), .err(err_tx));

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] q[$];
    int         cnt;
    bit         m_err;
    logic [7:0] m_rd;

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_stat(int c, bit rx);
        logic [15:0] s;
        s = 16'h2000;
        s[3:2] = 2'(c % D);
        if (rx) begin
            s[0] = (c != 0);
            s[1] = (c > D/2);
        end else begin
            s[0] = (c != D);
            s[1] = (c < D/2);
        end
        return s;
    endfunction

    task automatic check_all(string tag);
        check("R2",  "nonempty rx", 16'(ne_rx), 16'(cnt != 0));
        check("R2",  "nonempty tx", 16'(ne_tx), 16'(cnt != 0));
        check("R3",  "rd_byte rx", 16'(rd_rx), 16'(m_rd));
        check("R3",  "rd_byte tx", 16'(rd_tx), 16'(m_rd));
        check("R7",  "err rx", 16'(err_rx), 16'(m_err));
        check("R7",  "err tx", 16'(err_tx), 16'(m_err));
        check("R1",  "size field", {12'h0, st_tx[15:12]}, 16'h2);
        check("R8",  "fill field", {4'h0, st_rx[11:0] & 12'hffc}, {4'h0, exp_stat(cnt, 1'b1)[11:0] & 12'hffc});
        check("R9",  "rx irq bits", 16'(st_rx[1:0]), 16'(exp_stat(cnt, 1'b1)[1:0]));
        check("R10", "tx irq bits", 16'(st_tx[1:0]), 16'(exp_stat(cnt, 1'b0)[1:0]));
        check(tag,   "status rx", st_rx, exp_stat(cnt, 1'b1));
        check(tag,   "status tx", st_tx, exp_stat(cnt, 1'b0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk); #1;
        q.delete(); cnt = 0; m_err = 1'b0; m_rd = 8'h00;
        check_all("R11");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cyc(bit w, logic [7:0] d, bit r, string tag);
        bit pop, push;
        @(negedge clk);
        wr_en = w; wr_byte = d; rd_en = r;
        @(posedge clk); #1;
        pop  = r && (cnt > 0);
        push = w && (cnt < D || pop);
        if ((r && cnt == 0) || (w && !push)) m_err = 1'b1;
        if (pop) begin m_rd = q.pop_front(); cnt--; end
        if (push) begin q.push_back(d); cnt++; end
        check_all(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        cnt = 0; m_err = 1'b0; m_rd = 8'h00;
        do_reset();

        // R5: read from empty
        cyc(1'b0, 8'h00, 1'b1, "R5");
        cyc(1'b0, 8'h00, 1'b0, "R7");
        do_reset();

        // R2: fill, R6: overflow, R4: both on full, R3: drain
        for (int i = 0; i < D; i++) cyc(1'b1, 8'(8'h10 + i), 1'b0, "R2");
        cyc(1'b1, 8'hEE, 1'b0, "R6");
        cyc(1'b1, 8'h77, 1'b1, "R4");
        for (int i = 0; i < D; i++) cyc(1'b0, 8'h00, 1'b1, "R3");
        cyc(1'b0, 8'h00, 1'b1, "R5");
        do_reset();

        // R4: simultaneous strobes on partially filled buffer
        cyc(1'b1, 8'hA1, 1'b0, "R2");
        cyc(1'b1, 8'hA2, 1'b1, "R4");
        cyc(1'b1, 8'hA3, 1'b1, "R4");
        // R5: both strobes on empty buffer
        cyc(1'b0, 8'h00, 1'b1, "R3");
        cyc(1'b1, 8'hB0, 1'b1, "R5");

        // Sweep of strobe patterns with periodic flushes
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 700 == 699) do_reset();
            else cyc(lfsr[0], lfsr[15:8], lfsr[1] & lfsr[2] | lfsr[3] & ~lfsr[0],
                     (lfsr[0] && lfsr[1]) ? "R4" : "R8");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule